// File: doc/BRIEF.md
# ADC Result Bank

This block stores the converted codes of an analog-to-digital converter. There are nineteen result slots. A conversion engine outside the block reports each conversion with a start pulse and a done pulse, plus the slot number and the raw code. On the done pulse the block formats the raw code and writes it into that slot's result word. The word carries a valid flag and an overrun flag next to the data. A read of a result word clears both flags. Slots 0 to 3 can each be switched to double buffering. In that mode, successive results for the slot alternate between a primary register and a second register.

Each slot can raise interrupt flags, either at the start or at the end of its conversion. Four interrupt lines route these events, each through its own slot mask and its own enable. Setting a line flag that is already set also records a flag overrun. When DMA mode is selected, every completed conversion also emits a single-cycle DMA request.

Top module: `adcres_top`

## Requirements
- R1: On a done pulse for slot s, the formatted code is stored in the selected register of slot s. The read word then shows the code in bits 15:0, the overrun flag in bit 16 and the valid flag (1) in bit 17, starting the cycle after the pulse.
- R2: With fmtSigned=0 the 12-bit raw code is zero-extended to 16 bits. With fmtSigned=1 the raw MSB is inverted and sign-extended, so raw 0x000 gives 0xF800, 0x800 gives 0x0000 and 0xFFF gives 0x07FF.
- R3: A read (rdEn high for one cycle) returns the current word and clears that register's valid and overrun flags at the end of the cycle.
- R4: A capture into a register whose valid flag is still set stores the new code and sets its overrun flag.
- R5: anyValid is the OR of all valid flags and anyOverrun is the OR of all overrun flags, across primary and second registers.
- R6: With dbEnable[s] set (s = 0 to 3), captures for slot s alternate between the primary register and the second register, beginning with the primary one. With dbEnable[s] clear, every capture goes to the primary register. The second register is read with rdSecond=1.
- R7: Interrupt line l sets intFlag[l] only for slots whose bit is set in its mask. The mask occupies lineMask bits l*19 to l*19+18. The flag is also set only while lineEnable[l] is 1.
- R8: When intAtStart[s] is 1, slot s raises its interrupt event on the start pulse. Otherwise it raises it on the done pulse, and the other pulse raises no event.
- R9: An event that hits a line whose flag is already set sets flagOv[l]. anyFlagOv is the OR of flagOv. flagClr[l] clears both intFlag[l] and flagOv[l].
- R10: With dmaEnable=1, dmaReq is high for exactly the one cycle after each done pulse. With dmaEnable=0 it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| convStart | input | 1 | Start-of-conversion pulse for convSlot |
| convDone | input | 1 | End-of-conversion pulse; rawCode is valid |
| convSlot | input | 5 | Slot of the current conversion |
| rawCode | input | 12 | Unsigned converter code |
| fmtSigned | input | 1 | 0 straight binary, 1 two's complement |
| dbEnable | input | 4 | Double-buffer enable for slots 0 to 3 |
| intAtStart | input | 19 | Per-slot interrupt position (1 = start) |
| lineEnable | input | 4 | Per-line interrupt enable |
| lineMask | input | 76 | Four 19-bit slot masks, line l at bits l*19 and up |
| flagClr | input | 4 | Clear of line flags and flag overruns |
| dmaEnable | input | 1 | Emit DMA requests on completion |
| rdEn | input | 1 | Read strobe, clears the addressed flags |
| rdSlot | input | 5 | Slot to read |
| rdSecond | input | 1 | Read the second register (slots 0 to 3) |
| rdWord | output | 18 | {valid, overrun, data} of the addressed register |
| anyValid | output | 1 | OR of all valid flags |
| anyOverrun | output | 1 | OR of all overrun flags |
| intFlag | output | 4 | Per-line interrupt flags |
| flagOv | output | 4 | Per-line flag overrun bits |
| anyFlagOv | output | 1 | OR of flagOv |
| dmaReq | output | 1 | DMA request pulse |

## Verification
The bench captures twice into one slot without a read between, and so catches a design that drops the overrun or leaves it standing after the read. It drives three captures into a double-buffered slot. A buffer pointer that starts on the wrong register or fails to toggle then puts the codes in the wrong places. It also checks that a buffer-disabled slot leaves its second register empty. It tests the signed format at the code extremes and the midpoint, where an off-by-one in the sign extension shows. It also pairs start-position and end-position slots, so that a design that fires on the wrong pulse, or ignores a disabled line or a masked slot, sets the wrong flag bits.

// File: rtl/adcres_pkg.sv
package adcres_pkg;
  localparam int SLOTS  = 19;
  localparam int DBL    = 4;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int RES_W  = 16;

  // Strobes from control to datapath
  typedef struct packed {
    logic              wrEn;
    logic              wrSec;
    logic [SLOT_W-1:0] wrSlot;
    logic              rdEn;
    logic              rdSec;
    logic [SLOT_W-1:0] rdSlot;
  } strobe_t;
endpackage

// File: rtl/adcres_ctrl.sv
module adcres_ctrl
  import adcres_pkg::*;
#(
  parameter int NUM_SLOTS = SLOTS,
  parameter int NUM_DB    = DBL,
  parameter int NUM_LINES = 4
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           convStart,
  input  logic                           convDone,
  input  logic [SLOT_W-1:0]              convSlot,
  input  logic [NUM_DB-1:0]              dbEnable,
  input  logic [NUM_SLOTS-1:0]           intAtStart,
  input  logic [NUM_LINES-1:0]           lineEnable,
  input  logic [NUM_LINES*NUM_SLOTS-1:0] lineMask,
  input  logic [NUM_LINES-1:0]           flagClr,
  input  logic                           dmaEnable,
  input  logic                           rdEn,
  input  logic                           rdSecond,
  input  logic [SLOT_W-1:0]              rdSlot,
  output strobe_t                        stb,
  output logic [NUM_LINES-1:0]           intFlag,
  output logic [NUM_LINES-1:0]           flagOv,
  output logic                           dmaReq
);
  logic                 slotOk;
  logic [NUM_SLOTS-1:0] slotHot;
  logic [NUM_SLOTS-1:0] evtSlot;
  logic [NUM_LINES-1:0] lineHit;
  logic [NUM_DB-1:0]    bufSel;
  logic                 secPick;

  assign slotOk  = (int'(convSlot) < NUM_SLOTS);
  assign slotHot = slotOk ? (NUM_SLOTS'(1) << convSlot) : '0;
  assign evtSlot = slotHot & ((intAtStart & {NUM_SLOTS{convStart}}) |
                              (~intAtStart & {NUM_SLOTS{convDone}}));

  always_comb begin
    secPick = 1'b0;
    for (int d = 0; d < NUM_DB; d++)
      if (slotHot[d]) secPick = dbEnable[d] & bufSel[d];
  end

  assign stb.wrEn   = convDone & slotOk;
  assign stb.wrSec  = secPick;
  assign stb.wrSlot = convSlot;
  assign stb.rdEn   = rdEn;
  assign stb.rdSec  = rdSecond & (int'(rdSlot) < NUM_DB);
  assign stb.rdSlot = rdSlot;

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    assign lineHit[l] = lineEnable[l] & |(lineMask[l*NUM_SLOTS +: NUM_SLOTS] & evtSlot);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufSel  <= '0;
      intFlag <= '0;
      flagOv  <= '0;
      dmaReq  <= 1'b0;
    end else begin
      for (int d = 0; d < NUM_DB; d++) begin
        if (!dbEnable[d])                 bufSel[d] <= 1'b0;
        else if (convDone && slotHot[d])  bufSel[d] <= ~bufSel[d];
      end
      intFlag <= (intFlag & ~flagClr) | lineHit;
      flagOv  <= (flagOv & ~flagClr) | (lineHit & intFlag & ~flagClr);
      dmaReq  <= dmaEnable & convDone & slotOk;
    end
  end
endmodule

// File: rtl/adcres_datapath.sv
module adcres_datapath
  import adcres_pkg::*;
#(
  parameter int NUM_SLOTS = SLOTS,
  parameter int NUM_DB    = DBL,
  parameter int RAW_W     = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [RAW_W-1:0] rawCode,
  input  logic             fmtSigned,
  output logic [RES_W+1:0] rdWord,
  output logic             anyValid,
  output logic             anyOverrun
);
  localparam int PAD_W = RES_W - RAW_W;

  logic [RES_W-1:0]     fmtCode;
  logic [RES_W-1:0]     primData [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] primValid, primOv, primWr, primRd;
  logic [RES_W-1:0]     secData [NUM_DB];
  logic [NUM_DB-1:0]    secValid, secOv, secWr, secRd;

  assign fmtCode = fmtSigned
    ? {{(PAD_W+1){~rawCode[RAW_W-1]}}, rawCode[RAW_W-2:0]}
    : {{PAD_W{1'b0}}, rawCode};

  always_comb begin
    for (int i = 0; i < NUM_SLOTS; i++) begin
      primWr[i] = stb.wrEn & ~stb.wrSec & (stb.wrSlot == SLOT_W'(i));
      primRd[i] = stb.rdEn & ~stb.rdSec & (stb.rdSlot == SLOT_W'(i));
    end
    for (int d = 0; d < NUM_DB; d++) begin
      secWr[d] = stb.wrEn & stb.wrSec & (stb.wrSlot == SLOT_W'(d));
      secRd[d] = stb.rdEn & stb.rdSec & (stb.rdSlot == SLOT_W'(d));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SLOTS; i++) primData[i] <= '0;
      for (int d = 0; d < NUM_DB; d++)    secData[d]  <= '0;
      primValid <= '0;
      primOv    <= '0;
      secValid  <= '0;
      secOv     <= '0;
    end else begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        if (primWr[i]) begin
          primData[i]  <= fmtCode;
          primValid[i] <= 1'b1;
          primOv[i]    <= primOv[i] | primValid[i];
        end else if (primRd[i]) begin
          primValid[i] <= 1'b0;
          primOv[i]    <= 1'b0;
        end
      end
      for (int d = 0; d < NUM_DB; d++) begin
        if (secWr[d]) begin
          secData[d]  <= fmtCode;
          secValid[d] <= 1'b1;
          secOv[d]    <= secOv[d] | secValid[d];
        end else if (secRd[d]) begin
          secValid[d] <= 1'b0;
          secOv[d]    <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    rdWord = '0;
    if (stb.rdSec) begin
      for (int d = 0; d < NUM_DB; d++)
        if (stb.rdSlot == SLOT_W'(d)) rdWord = {secValid[d], secOv[d], secData[d]};
    end else begin
      for (int i = 0; i < NUM_SLOTS; i++)
        if (stb.rdSlot == SLOT_W'(i)) rdWord = {primValid[i], primOv[i], primData[i]};
    end
  end

  assign anyValid   = |primValid | |secValid;
  assign anyOverrun = |primOv | |secOv;
endmodule

// File: rtl/adcres_top.sv
module adcres_top
  import adcres_pkg::*;
#(
  parameter int NUM_SLOTS = SLOTS,
  parameter int NUM_DB    = DBL,
  parameter int NUM_LINES = 4,
  parameter int RAW_W     = 12
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           convStart,
  input  logic                           convDone,
  input  logic [SLOT_W-1:0]              convSlot,
  input  logic [RAW_W-1:0]               rawCode,
  input  logic                           fmtSigned,
  input  logic [NUM_DB-1:0]              dbEnable,
  input  logic [NUM_SLOTS-1:0]           intAtStart,
  input  logic [NUM_LINES-1:0]           lineEnable,
  input  logic [NUM_LINES*NUM_SLOTS-1:0] lineMask,
  input  logic [NUM_LINES-1:0]           flagClr,
  input  logic                           dmaEnable,
  input  logic                           rdEn,
  input  logic [SLOT_W-1:0]              rdSlot,
  input  logic                           rdSecond,
  output logic [RES_W+1:0]               rdWord,
  output logic                           anyValid,
  output logic                           anyOverrun,
  output logic [NUM_LINES-1:0]           intFlag,
  output logic [NUM_LINES-1:0]           flagOv,
  output logic                           anyFlagOv,
  output logic                           dmaReq
);
  strobe_t stb;

  adcres_ctrl #(.NUM_SLOTS(NUM_SLOTS), .NUM_DB(NUM_DB), .NUM_LINES(NUM_LINES)) u_ctrl (
    .clk(clk), .rstN(rstN), .convStart(convStart), .convDone(convDone),
    .convSlot(convSlot), .dbEnable(dbEnable), .intAtStart(intAtStart),
    .lineEnable(lineEnable), .lineMask(lineMask), .flagClr(flagClr),
    .dmaEnable(dmaEnable), .rdEn(rdEn), .rdSecond(rdSecond), .rdSlot(rdSlot),
    .stb(stb), .intFlag(intFlag), .flagOv(flagOv), .dmaReq(dmaReq)
  );

  adcres_datapath #(.NUM_SLOTS(NUM_SLOTS), .NUM_DB(NUM_DB), .RAW_W(RAW_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .rawCode(rawCode), .fmtSigned(fmtSigned),
    .rdWord(rdWord), .anyValid(anyValid), .anyOverrun(anyOverrun)
  );

  assign anyFlagOv = |flagOv;
endmodule

// File: rtl/adcres_chk.sv
module adcres_chk
  import adcres_pkg::*;
#(
  parameter int NUM_SLOTS = SLOTS,
  parameter int NUM_LINES = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 convStart,
  input logic                 convDone,
  input logic [SLOT_W-1:0]    convSlot,
  input logic                 dmaEnable,
  input logic [NUM_LINES-1:0] flagClr,
  input logic [NUM_LINES-1:0] intFlag,
  input logic [NUM_LINES-1:0] flagOv,
  input logic                 anyFlagOv,
  input logic                 anyValid,
  input logic                 anyOverrun,
  input logic                 dmaReq
);
  // R1
  valid_after_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    (convDone && int'(convSlot) < NUM_SLOTS) |=> anyValid);

  // R4
  overrun_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(anyOverrun) |-> $past(convDone));

  // R9
  flag_ov_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(anyFlagOv) |-> $past(|intFlag));

  // R9
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((&flagClr) && !convStart && !convDone) |=> (intFlag == '0 && flagOv == '0));

  // R10
  dma_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (convDone && dmaEnable && int'(convSlot) < NUM_SLOTS) |=> dmaReq);

  // R10
  dma_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq |-> $past(convDone && dmaEnable));
endmodule

bind adcres_top adcres_chk #(.NUM_SLOTS(NUM_SLOTS), .NUM_LINES(NUM_LINES)) u_chk (
  .clk(clk), .rstN(rstN), .convStart(convStart), .convDone(convDone),
  .convSlot(convSlot), .dmaEnable(dmaEnable), .flagClr(flagClr),
  .intFlag(intFlag), .flagOv(flagOv), .anyFlagOv(anyFlagOv),
  .anyValid(anyValid), .anyOverrun(anyOverrun), .dmaReq(dmaReq)
);

// File: tb/adcres_top_tb.sv
module adcres_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        convStart = 1'b0, convDone = 1'b0;
  logic [4:0]  convSlot = '0;
  logic [11:0] rawCode = '0;
  logic        fmtSigned = 1'b0;
  logic [3:0]  dbEnable = '0;
  logic [18:0] intAtStart = '0;
  logic [3:0]  lineEnable = '0;
  logic [75:0] lineMask = '0;
  logic [3:0]  flagClr = '0;
  logic        dmaEnable = 1'b0;
  logic        rdEn = 1'b0;
  logic [4:0]  rdSlot = '0;
  logic        rdSecond = 1'b0;
  logic [17:0] rdWord;
  logic        anyValid, anyOverrun, anyFlagOv, dmaReq;
  logic [3:0]  intFlag, flagOv;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [17:0] expQ[$];
  string       tagQ[$];

  always #10 clk = ~clk;

  adcres_top u_dut (
    .clk(clk), .rstN(rstN), .convStart(convStart), .convDone(convDone),
    .convSlot(convSlot), .rawCode(rawCode), .fmtSigned(fmtSigned),
    .dbEnable(dbEnable), .intAtStart(intAtStart), .lineEnable(lineEnable),
    .lineMask(lineMask), .flagClr(flagClr), .dmaEnable(dmaEnable),
    .rdEn(rdEn), .rdSlot(rdSlot), .rdSecond(rdSecond), .rdWord(rdWord),
    .anyValid(anyValid), .anyOverrun(anyOverrun), .intFlag(intFlag),
    .flagOv(flagOv), .anyFlagOv(anyFlagOv), .dmaReq(dmaReq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops the expected read word while the read strobe is high
  always @(negedge clk) begin
    if (rdEn && expQ.size() > 0) chk(tagQ.pop_front(), 32'(rdWord), 32'(expQ.pop_front()));
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic pulseStart(input int s);
    convStart = 1'b1; convSlot = 5'(s);
    step();
    convStart = 1'b0;
  endtask

  task automatic pulseDone(input int s, input logic [11:0] r);
    convDone = 1'b1; convSlot = 5'(s); rawCode = r;
    step();
    convDone = 1'b0;
  endtask

  task automatic conv(input int s, input logic [11:0] r);
    pulseStart(s);
    pulseDone(s, r);
  endtask

  // Driver: pushes the expected word, then issues the read
  task automatic readWord(input int s, input bit sec, input logic [17:0] exp, input string tag);
    expQ.push_back(exp); tagQ.push_back(tag);
    rdEn = 1'b1; rdSlot = 5'(s); rdSecond = sec;
    step();
    rdEn = 1'b0; rdSecond = 1'b0;
  endtask

  task automatic clearFlags();
    flagClr = 4'hF;
    step();
    flagClr = 4'h0;
  endtask

  function automatic logic [15:0] fmt(input logic [11:0] r, input bit sgn);
    return sgn ? {{5{~r[11]}}, r[10:0]} : {4'h0, r};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    step();
    // reset state
    chk("R5 reset anyValid", 32'(anyValid), 0);
    chk("R5 reset anyOverrun", 32'(anyOverrun), 0);
    chk("R9 reset intFlag", 32'(intFlag), 0);
    chk("R10 reset dmaReq", 32'(dmaReq), 0);
    readWord(0, 0, 18'h0, "R3 reset word");

    // R7: masks and enables; line3 has slot 5 but is disabled
    lineMask[0*19 + 5]  = 1'b1;
    lineMask[1*19 + 2]  = 1'b1;
    lineMask[2*19 + 18] = 1'b1;
    lineMask[3*19 + 5]  = 1'b1;
    lineEnable = 4'b0111;
    intAtStart[18] = 1'b1;

    conv(5, 12'h123);
    chk("R10 dma off", 32'(dmaReq), 0);
    chk("R5 anyValid after capture", 32'(anyValid), 1);
    chk("R7 line routing", 32'(intFlag), 32'h1);
    readWord(5, 0, {2'b10, fmt(12'h123, 0)}, "R1 capture word");
    chk("R3 valid cleared", 32'(anyValid), 0);

    // R4 overrun and R9 flag overrun
    conv(5, 12'h3AA);
    conv(5, 12'h456);
    chk("R5 anyOverrun", 32'(anyOverrun), 1);
    chk("R9 flagOv", 32'(flagOv), 32'h1);
    chk("R9 anyFlagOv", 32'(anyFlagOv), 1);
    readWord(5, 0, {2'b11, 16'h0456}, "R4 overrun word");
    readWord(5, 0, {2'b00, 16'h0456}, "R3 second read");
    chk("R3 overrun cleared", 32'(anyOverrun), 0);
    clearFlags();
    chk("R9 flags cleared", 32'({intFlag, flagOv, 3'b0, anyFlagOv}), 0);

    // R2 two's complement, slot 7 unmasked
    fmtSigned = 1'b1;
    conv(7, 12'h000);
    readWord(7, 0, {2'b10, 16'hF800}, "R2 min code");
    conv(7, 12'hFFF);
    readWord(7, 0, {2'b10, 16'h07FF}, "R2 max code");
    conv(7, 12'h800);
    readWord(7, 0, {2'b10, 16'h0000}, "R2 mid code");
    chk("R7 unmasked slot", 32'(intFlag), 0);
    fmtSigned = 1'b0;

    // R8 start vs end position
    pulseStart(18);
    chk("R8 start position", 32'(intFlag), 32'h4);
    pulseStart(2);
    chk("R8 end slot no start event", 32'(intFlag), 32'h4);
    pulseDone(2, 12'h0BC);
    chk("R8 end position", 32'(intFlag), 32'h6);
    pulseDone(18, 12'h0AA);
    chk("R8 no done event for start slot", 32'(flagOv), 0);
    readWord(2, 0, {2'b10, 16'h00BC}, "R1 slot2 word");
    readWord(18, 0, {2'b10, 16'h00AA}, "R1 slot18 word");
    clearFlags();

    // R6 double buffering
    dbEnable = 4'b0010;
    conv(1, 12'h111);
    conv(1, 12'h222);
    conv(1, 12'h333);
    readWord(1, 0, {2'b11, 16'h0333}, "R6 primary alternation");
    readWord(1, 1, {2'b10, 16'h0222}, "R6 second register");
    conv(3, 12'h0AB);
    conv(3, 12'h0CD);
    readWord(3, 0, {2'b11, 16'h00CD}, "R6 disabled slot primary");
    readWord(3, 1, 18'h0, "R6 disabled slot second empty");
    chk("R5 all clear", 32'({anyValid, anyOverrun}), 0);

    // R10 DMA request, interrupts disabled
    lineMask[0*19 + 9] = 1'b1;
    lineEnable = 4'b0000;
    dmaEnable = 1'b1;
    pulseDone(9, 12'h321);
    chk("R10 dma pulse", 32'(dmaReq), 1);
    step();
    chk("R10 dma single cycle", 32'(dmaReq), 0);
    chk("R7 disabled line", 32'(intFlag), 0);
    readWord(9, 0, {2'b10, 16'h0321}, "R1 dma slot word");

    step();
    step();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule